// File: doc/BRIEF.md
# Cacheable Page Remap Unit

This unit sits between a processor's address output and the system bus. The bottom 32 MB of the processor's address space is a window made of 16 pages of 2 MB each. Every page owns an 11-bit upper-address value. When an access falls inside the window, that value takes the place of the top 11 address bits, so any 2 MB region of the 32-bit space can be seen through a low page. Addresses outside the window reach the bus unchanged.

Along with each translated address the unit reports whether the access may be cached. That flag needs four things at once: a valid access, an address inside the window, the page's bit set in a 16-bit enable mask, and the global enable for the access type (data or instruction) set.

A small configuration port writes and reads the page values and the mask. The page values leave reset already pointing at a fixed set of physical regions, so translation is in effect before software touches the unit.

Top module: `cwin_remap`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `bus_valid`, `bus_cacheable`, `bus_addr` and `cfg_rdata` are zero. The enable mask resets to all zeros.
- R2: Page values leave reset as follows, for pages 0 through 15: 0x0, 0x1, 0x2, 0x2, 0x82, 0x100, 0x100, 0x180, 0x180, 0x400, 0x401, 0x102, 0x104, 0x106, 0xE, 0xF.
- R3: When `cpu_addr[31:25]` is zero, the page is `cpu_addr[24:21]`. `bus_addr` is then {page value, `cpu_addr[20:0]`}. Examples: 0x0121_4A90 with page 9 at 0x82 becomes 0x1041_4A90. 0x0060_0004 with page 3 at 0x082 becomes 0x1040_0004.
- R4: When `cpu_addr[31:25]` is not zero, `bus_addr` equals `cpu_addr` and `bus_cacheable` is 0. This holds even when the address is a physical target of some page.
- R5: `bus_cacheable` is 1 only when all of these hold: `cpu_valid`, an address inside the window, the page's mask bit, and the global enable of the access type (`instr_en` when `cpu_is_instr` is 1, else `data_en`).
- R6: While a global enable is 0, no access of that type is cacheable on any page, whatever the mask holds.
- R7: The configuration port uses word offsets on `cfg_addr`. Offsets 0–15 are page values, held in data bits [10:0]. Offset 16 is the mask: bit n enables page n. Unused bits and unused offsets read as zero. Writes to unused offsets change nothing. `cfg_rdata` shows the addressed register one cycle after `cfg_addr`, with its value from before any write made in that same cycle.
- R8: The outputs are registered. `bus_valid`, `bus_addr` and `bus_cacheable` reflect the inputs of the previous cycle. A write takes effect for accesses presented in the cycle after the write.
- R9: Remapping is active from reset. With no programming, 0x0080_0010 (page 4) reaches the bus as 0x1040_0010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration word offset |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_rdata | output | 16 | Registered read data for the offset of the previous cycle |
| data_en | input | 1 | Global enable for caching data accesses |
| instr_en | input | 1 | Global enable for caching instruction accesses |
| cpu_valid | input | 1 | Processor access present |
| cpu_addr | input | 32 | Processor address |
| cpu_is_instr | input | 1 | 1 for an instruction fetch, 0 for a data access |
| bus_valid | output | 1 | Registered access valid |
| bus_addr | output | 32 | Registered translated address |
| bus_cacheable | output | 1 | Registered cacheable flag |

## Verification
The hardest case to reach from the ports is a cycle in which a configuration write and an access to the page being written coincide. The access must still use the old page value or mask bit, and a read of that offset in the same cycle must return the old contents. A second hard case is the physical alias of a remapped page, which must stay non-cacheable. The stimulus reaches these through a long random run. In that run writes land on live pages, most addresses stay inside the window, and the global enables toggle. Directed steps come first: they cover the worked examples, the reserved bits, the alias addresses, and the enable combinations one at a time.

// File: rtl/cwin_pkg.sv
package cwin_pkg;
  // Power-on upper-address value of each page; idx outside 0..15 gives 0.
  function automatic logic [31:0] page_reset_val(input int idx);
    case (idx)
      0:  page_reset_val = 32'h000;
      1:  page_reset_val = 32'h001;
      2:  page_reset_val = 32'h002;
      3:  page_reset_val = 32'h002;
      4:  page_reset_val = 32'h082;
      5:  page_reset_val = 32'h100;
      6:  page_reset_val = 32'h100;
      7:  page_reset_val = 32'h180;
      8:  page_reset_val = 32'h180;
      9:  page_reset_val = 32'h400;
      10: page_reset_val = 32'h401;
      11: page_reset_val = 32'h102;
      12: page_reset_val = 32'h104;
      13: page_reset_val = 32'h106;
      14: page_reset_val = 32'h00E;
      15: page_reset_val = 32'h00F;
      default: page_reset_val = 32'h000;
    endcase
  endfunction
endpackage

// File: rtl/cwin_regfile.sv
module cwin_regfile #(
  parameter int PAGES  = 16,
  parameter int UW     = 11,
  parameter int CFG_AW = 5,
  parameter int CFG_DW = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      cfg_we,
  input  logic [CFG_AW-1:0]         cfg_addr,
  input  logic [CFG_DW-1:0]         cfg_wdata,
  output logic [CFG_DW-1:0]         cfg_rdata,
  output logic [PAGES-1:0][UW-1:0]  page_tbl,
  output logic [PAGES-1:0]          page_mask
);
  import cwin_pkg::*;

  localparam int PB = $clog2(PAGES);
  localparam logic [CFG_AW-1:0] MASK_OFS = CFG_AW'(PAGES);

  // One register per page, each with its own power-on value.
  for (genvar i = 0; i < PAGES; i++) begin : g_page
    always_ff @(posedge clk) begin
      if (rst)
        page_tbl[i] <= UW'(page_reset_val(i));
      else if (cfg_we && cfg_addr == CFG_AW'(i))
        page_tbl[i] <= cfg_wdata[UW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      page_mask <= '0;
    else if (cfg_we && cfg_addr == MASK_OFS)
      page_mask <= cfg_wdata[PAGES-1:0];
  end

  // Registered read-back; same-cycle writes are not yet visible.
  always_ff @(posedge clk) begin
    if (rst)
      cfg_rdata <= '0;
    else if (cfg_addr < MASK_OFS)
      cfg_rdata <= CFG_DW'(page_tbl[cfg_addr[PB-1:0]]);
    else if (cfg_addr == MASK_OFS)
      cfg_rdata <= CFG_DW'(page_mask);
    else
      cfg_rdata <= '0;
  end
endmodule

// File: rtl/cwin_xlate.sv
module cwin_xlate #(
  parameter int PAGES = 16,
  parameter int UW    = 11,
  parameter int AW    = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [PAGES-1:0][UW-1:0]  page_tbl,
  input  logic [PAGES-1:0]          page_mask,
  input  logic                      data_en,
  input  logic                      instr_en,
  input  logic                      cpu_valid,
  input  logic [AW-1:0]             cpu_addr,
  input  logic                      cpu_is_instr,
  output logic                      bus_valid,
  output logic [AW-1:0]             bus_addr,
  output logic                      bus_cacheable
);
  localparam int LOW_W = AW - UW;
  localparam int PB    = $clog2(PAGES);
  localparam int TOP_W = AW - LOW_W - PB;

  logic [PB-1:0] page;
  logic          in_win;
  logic          type_en;
  logic [AW-1:0] mapped;
  logic          cach_nxt;

  always_comb begin
    page     = cpu_addr[LOW_W +: PB];
    in_win   = (cpu_addr[AW-1 -: TOP_W] == '0);
    type_en  = cpu_is_instr ? instr_en : data_en;
    mapped   = in_win ? {page_tbl[page], cpu_addr[LOW_W-1:0]} : cpu_addr;
    cach_nxt = cpu_valid & in_win & page_mask[page] & type_en;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_valid     <= 1'b0;
      bus_addr      <= '0;
      bus_cacheable <= 1'b0;
    end else begin
      bus_valid     <= cpu_valid;
      bus_addr      <= mapped;
      bus_cacheable <= cach_nxt;
    end
  end
endmodule

// File: rtl/cwin_remap.sv
module cwin_remap #(
  parameter int PAGES  = 16,
  parameter int UW     = 11,
  parameter int AW     = 32,
  parameter int CFG_AW = 5,
  parameter int CFG_DW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CFG_DW-1:0] cfg_wdata,
  output logic [CFG_DW-1:0] cfg_rdata,
  input  logic              data_en,
  input  logic              instr_en,
  input  logic              cpu_valid,
  input  logic [AW-1:0]     cpu_addr,
  input  logic              cpu_is_instr,
  output logic              bus_valid,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_cacheable
);
  logic [PAGES-1:0][UW-1:0] page_tbl;
  logic [PAGES-1:0]         page_mask;

  cwin_regfile #(.PAGES(PAGES), .UW(UW), .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .page_tbl(page_tbl), .page_mask(page_mask)
  );

  cwin_xlate #(.PAGES(PAGES), .UW(UW), .AW(AW)) u_xlate (
    .clk(clk), .rst(rst), .page_tbl(page_tbl), .page_mask(page_mask),
    .data_en(data_en), .instr_en(instr_en), .cpu_valid(cpu_valid),
    .cpu_addr(cpu_addr), .cpu_is_instr(cpu_is_instr),
    .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_cacheable(bus_cacheable)
  );
endmodule

// File: rtl/cwin_remap_chk.sv
module cwin_remap_chk #(
  parameter int AW = 32,
  parameter int UW = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          data_en,
  input logic          instr_en,
  input logic          cpu_valid,
  input logic [AW-1:0] cpu_addr,
  input logic          cpu_is_instr,
  input logic          bus_valid,
  input logic [AW-1:0] bus_addr,
  input logic          bus_cacheable
);
  localparam int LOW_W = AW - UW;
  localparam int HI_W  = AW - LOW_W - 4;

  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
    cpu_valid |=> bus_valid);
  assert_idle_follow_R8: assert property (@(posedge clk) disable iff (rst)
    !cpu_valid |=> !bus_valid);
  assert_low_bits_R3: assert property (@(posedge clk) disable iff (rst)
    seen |-> bus_addr[LOW_W-1:0] == $past(cpu_addr[LOW_W-1:0]));
  assert_passthru_R4: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(cpu_addr[AW-1 -: HI_W]) != '0) |->
      (bus_addr == $past(cpu_addr) && !bus_cacheable));
  assert_cach_valid_R5: assert property (@(posedge clk) disable iff (rst)
    bus_cacheable |-> bus_valid);
  assert_global_en_R6: assert property (@(posedge clk) disable iff (rst)
    (seen && bus_cacheable) |-> $past(cpu_is_instr ? instr_en : data_en));
endmodule

bind cwin_remap cwin_remap_chk #(.AW(AW), .UW(UW)) u_chk (
  .clk(clk), .rst(rst), .data_en(data_en), .instr_en(instr_en),
  .cpu_valid(cpu_valid), .cpu_addr(cpu_addr), .cpu_is_instr(cpu_is_instr),
  .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_cacheable(bus_cacheable)
);

// File: tb/sim_cwin_remap.sv
`timescale 1ns/1ps
module sim_cwin_remap;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        data_en = 1'b0, instr_en = 1'b0;
  logic        cpu_valid = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        cpu_is_instr = 1'b0;
  logic        bus_valid, bus_cacheable;
  logic [31:0] bus_addr;

  always #4 clk = ~clk;

  cwin_remap u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .data_en(data_en),
    .instr_en(instr_en), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .cpu_is_instr(cpu_is_instr), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_cacheable(bus_cacheable)
  );

  int checks = 0, errors = 0;
  bit cmp_on = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int unsigned rv[16] = '{32'h0, 32'h1, 32'h2, 32'h2, 32'h82, 32'h100, 32'h100, 32'h180,
                          32'h180, 32'h400, 32'h401, 32'h102, 32'h104, 32'h106, 32'hE, 32'hF};
  int unsigned pg[16];
  int unsigned msk;
  logic        e_v, e_c, e_win;
  logic [31:0] e_a;
  logic [15:0] e_r;

  always @(posedge clk) begin
    if (rst) begin
      e_v = 0; e_c = 0; e_a = 0; e_r = 0; e_win = 0; msk = 0;
      foreach (pg[i]) pg[i] = rv[i];
    end else begin
      int p;
      bit te;
      p     = int'(cpu_addr[24:21]);
      e_win = (cpu_addr < 32'h0200_0000);
      te    = cpu_is_instr ? instr_en : data_en;
      e_v   = cpu_valid;
      e_a   = e_win ? ((pg[p] << 21) | (cpu_addr & 32'h001F_FFFF)) : cpu_addr;
      e_c   = cpu_valid && e_win && msk[p] && te;
      if (cfg_addr < 16)       e_r = 16'(pg[cfg_addr]);
      else if (cfg_addr == 16) e_r = 16'(msk);
      else                     e_r = 0;
      if (cfg_we) begin
        if (cfg_addr < 16)       pg[cfg_addr] = cfg_wdata & 16'h07FF;
        else if (cfg_addr == 16) msk = cfg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R8 bus_valid", 32'(bus_valid), 32'(e_v));
      chk(e_win ? "R3 bus_addr" : "R4 bus_addr", bus_addr, e_a);
      chk("R5 bus_cacheable", 32'(bus_cacheable), 32'(e_c));
      chk("R7 cfg_rdata", 32'(cfg_rdata), 32'(e_r));
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d; cyc(); cfg_we = 0;
  endtask

  task automatic acc(input logic [31:0] a, input logic ins);
    cpu_valid = 1; cpu_addr = a; cpu_is_instr = ins; cyc(); cpu_valid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    chk("R1 reset bus_valid", 32'(bus_valid), 0);
    chk("R1 reset bus_addr", bus_addr, 0);
    chk("R1 reset cfg_rdata", 32'(cfg_rdata), 0);
    rst = 0;
    cyc();
    chk("R1 post-reset cacheable", 32'(bus_cacheable), 0);
    cmp_on = 1;

    // R2: power-on page values
    for (int i = 0; i < 16; i++) begin
      cfg_addr = 5'(i); cyc();
      chk("R2 page reset value", 32'(cfg_rdata), rv[i]);
    end
    cfg_addr = 16; cyc(); chk("R1 mask reset", 32'(cfg_rdata), 0);
    cfg_addr = 21; cyc(); chk("R7 unused offset", 32'(cfg_rdata), 0);

    // R9: remapping active with no programming
    acc(32'h0080_0010, 0);
    chk("R9 default remap", bus_addr, 32'h1040_0010);
    chk("R9 not cacheable with empty mask", 32'(bus_cacheable), 0);

    // R3 worked examples
    wr(9, 16'h0082);
    acc(32'h0121_4A90, 0);
    chk("R3 example page9", bus_addr, 32'h1041_4A90);
    wr(3, 16'hFFFF);
    cfg_addr = 3; cyc(); chk("R7 reserved bits zero", 32'(cfg_rdata), 32'h7FF);
    wr(3, 16'h0082);
    acc(32'h0060_0004, 0);
    chk("R3 example page3", bus_addr, 32'h1040_0004);

    // R5 / R6 gating
    wr(16, 16'h0008);
    data_en = 1; instr_en = 0;
    acc(32'h0060_0004, 0); chk("R5 data page3 cacheable", 32'(bus_cacheable), 1);
    acc(32'h0060_0004, 1); chk("R6 instr disabled", 32'(bus_cacheable), 0);
    acc(32'h0080_0004, 0); chk("R5 page4 mask clear", 32'(bus_cacheable), 0);
    acc(32'h1040_0004, 0);
    chk("R4 alias passthrough", bus_addr, 32'h1040_0004);
    chk("R4 alias not cacheable", 32'(bus_cacheable), 0);
    wr(16, 16'hFFFF);
    data_en = 0; instr_en = 1;
    acc(32'h0080_0004, 0); chk("R6 data disabled all pages", 32'(bus_cacheable), 0);
    acc(32'h0080_0004, 1); chk("R6 instr enabled", 32'(bus_cacheable), 1);

    // R7 write to unused offset has no effect
    wr(20, 16'h1234);
    cfg_addr = 16; cyc(); chk("R7 mask untouched", 32'(cfg_rdata), 32'hFFFF);
    cfg_addr = 4;  cyc(); chk("R7 page4 untouched", 32'(cfg_rdata), 32'h082);

    // R8 same-cycle write and access use the old value
    cfg_we = 1; cfg_addr = 4; cfg_wdata = 16'h0055;
    cpu_valid = 1; cpu_addr = 32'h0080_0000; cpu_is_instr = 1;
    cyc(); cfg_we = 0;
    chk("R8 old value in write cycle", bus_addr, 32'h1040_0000);
    chk("R7 old readback in write cycle", 32'(cfg_rdata), 32'h082);
    cyc();
    chk("R8 new value next cycle", bus_addr, 32'h0AA0_0000);
    cpu_valid = 0;

    // Random traffic against the model
    for (int n = 0; n < 3000; n++) begin
      cfg_we    = ($urandom_range(0, 9) == 0);
      cfg_addr  = 5'($urandom_range(0, 20));
      cfg_wdata = 16'($urandom);
      cpu_valid = $urandom_range(0, 3) != 0;
      cpu_addr  = ($urandom_range(0, 4) != 0) ? ($urandom & 32'h01FF_FFFF) : $urandom;
      cpu_is_instr = $urandom_range(0, 1) == 1;
      if ($urandom_range(0, 15) == 0) data_en  = ~data_en;
      if ($urandom_range(0, 15) == 0) instr_en = ~instr_en;
      cyc();
    end
    cfg_we = 0; cpu_valid = 0;
    cyc(); cyc();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule